// File: doc/BRIEF.md
# Phase-Frequency Detector with Turbo Pump-Current Control

This block compares two divided pulse trains, one derived from the reference and one fed back from the oscillator divider. Both are sampled on a fast logic clock. Each input has an edge latch. The latch of whichever input rises first stays set until the other input also rises. Both latches are then held together for a fixed number of clock cycles and released. This gives the usual three output states: pump up, pump down, or idle. A polarity input chooses which latch drives the up command, so the block works with oscillators whose frequency rises or falls with tuning voltage.

Each completed comparison produces a width measurement: the number of cycles during which only one latch was set. A comparison counts as good when that width is below a programmable threshold. A run of consecutive good comparisons declares lock, and a shorter run of consecutive bad ones withdraws it. A 3-bit current-select output tells the analog pump which current to use. While turbo is armed and enabled, the output selects a high acquisition current. Once lock is reached, it switches to the 2-bit code of the active ratio set. Only a configuration-write strobe arms turbo again.

Top module: `pfd_turbo_ctrl`

## Requirements
- R1: After reset, pumpUp, pumpDn and locked are 0, and turbo is armed, so pumpCur reads 3'b100 whenever turboEn is 1.
- R2: A rising edge on refPulse sets the reference latch and a rising edge on fbPulse sets the feedback latch. Once both latches are set, pumpUp and pumpDn are high together for exactly RST_DLY cycles (default 2), and then both return low.
- R3: With polarity=1 the reference latch drives pumpUp and the feedback latch drives pumpDn. With polarity=0 the two are swapped.
- R4: The single-sided pulse, where one pump command is high and the other is low, lasts exactly as many cycles as separate the two input edges. Simultaneous edges give no single-sided pulse.
- R5: A comparison is good when its single-sided width is strictly less than lockThresh. Otherwise it is bad.
- R6: While unlocked, locked rises after LOCK_CNT (default 16) consecutive good comparisons. Any bad comparison restarts that count.
- R7: While locked, locked falls after UNLOCK_CNT (default 4) consecutive bad comparisons. Any good comparison restarts that count.
- R8: pumpCur bit 2 set (value 3'b100) selects the acquisition current. Otherwise pumpCur = {1'b0, code}, where code is curCodeOne when setSel=1 and curCodeTwo when setSel=0. Code 00/01/10/11 stands for 150/210/300/425 µA; 11 is the recommended power-on value.
- R9: pumpCur is 3'b100 only while turbo is armed and turboEn=1. Turbo is disarmed in the cycle that lock is declared. A later loss of lock does not arm it again.
- R10: A one-cycle cfgWrite pulse arms turbo, clears locked and restarts both comparison counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast logic clock |
| rstN | input | 1 | Active-low synchronous reset |
| refPulse | input | 1 | Divided reference pulse |
| fbPulse | input | 1 | Divided oscillator feedback pulse |
| polarity | input | 1 | 1: reference latch drives pumpUp; 0: swapped |
| turboEn | input | 1 | Allows the acquisition current while turbo is armed |
| curCodeOne | input | 2 | Programmed current code of ratio set one |
| curCodeTwo | input | 2 | Programmed current code of ratio set two |
| setSel | input | 1 | 1 selects set one, 0 selects set two |
| cfgWrite | input | 1 | Configuration-write strobe; arms turbo and restarts lock search |
| lockThresh | input | 8 | Width limit in cycles for a good comparison |
| pumpUp | output | 1 | Pump source command |
| pumpDn | output | 1 | Pump sink command |
| locked | output | 1 | High while the loop is declared locked |
| pumpCur | output | 3 | Pump current select: 3'b100 turbo, else {0, code} |

## Verification
The embedded properties assume the following about the inputs:
- Both pulse inputs are synchronous to clk.
- polarity changes only while both latches are clear and no edge is arriving.
- No new edge lands in the cycle in which the latches are released.

The stimulus meets these conditions by driving each comparison as a single one-cycle reference pulse and a single one-cycle feedback pulse, at a chosen spacing. It then idles long enough for the release and the lock update to finish before the next comparison starts. Polarity, codes and the set select are changed only in those idle gaps.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Strobes from the phase core to the lock/turbo control.
  typedef struct packed {
    logic cmpDone;  // a comparison finished this cycle
    logic cmpOk;    // its single-sided width was below the threshold
  } cmpStrobeT;

  localparam logic [2:0] CUR_TURBO = 3'b100;
endpackage

// File: rtl/pfd_phase_core.sv
module pfd_phase_core
  import pfd_pkg::*;
#(
  parameter int RST_DLY = 2,
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refPulse,
  input  logic               fbPulse,
  input  logic               polarity,
  input  logic [WIDTH_W-1:0] lockThresh,
  output logic               pumpUp,
  output logic               pumpDn,
  output cmpStrobeT          strobe
);
  localparam int DLY_W = $clog2(RST_DLY + 1);

  logic refPrev, fbPrev, refLat, fbLat;
  logic refEdge, fbEdge, bothSet, clrNow;
  logic [DLY_W-1:0]   dlyCnt;
  logic [WIDTH_W-1:0] gapCnt;

  assign refEdge = refPulse & ~refPrev;
  assign fbEdge  = fbPulse & ~fbPrev;
  assign bothSet = refLat & fbLat;
  assign clrNow  = bothSet && (dlyCnt == DLY_W'(RST_DLY - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      fbPrev  <= 1'b0;
      refLat  <= 1'b0;
      fbLat   <= 1'b0;
      dlyCnt  <= '0;
      gapCnt  <= '0;
    end else begin
      refPrev <= refPulse;
      fbPrev  <= fbPulse;
      refLat  <= clrNow ? 1'b0 : (refLat | refEdge);
      fbLat   <= clrNow ? 1'b0 : (fbLat | fbEdge);
      dlyCnt  <= (clrNow || !bothSet) ? '0 : dlyCnt + 1'b1;
      if (clrNow)
        gapCnt <= '0;
      else if ((refLat ^ fbLat) && (gapCnt != '1))
        gapCnt <= gapCnt + 1'b1;
    end
  end

  assign pumpUp         = polarity ? refLat : fbLat;
  assign pumpDn         = polarity ? fbLat  : refLat;
  assign strobe.cmpDone = clrNow;
  assign strobe.cmpOk   = gapCnt < lockThresh;

  // Run length of simultaneous up/down, observed at the outputs.
  logic [DLY_W:0] bothRun;
  always_ff @(posedge clk) begin
    if (!rstN)                bothRun <= '0;
    else if (pumpUp && pumpDn) bothRun <= bothRun + 1'b1;
    else                      bothRun <= '0;
  end

  a_r2_both_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bothRun <= (DLY_W+1)'(RST_DLY));

  a_r3_ref_edge_routed: assert property (@(posedge clk) disable iff (!rstN)
    (refEdge && !fbEdge && !refLat && !fbLat) |=>
      (polarity ? (pumpUp && !pumpDn) : (pumpDn && !pumpUp)));

  a_r4_done_needs_both: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmpDone |-> (pumpUp && pumpDn));
endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl
  import pfd_pkg::*;
#(
  parameter int LOCK_CNT   = 16,
  parameter int UNLOCK_CNT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  cmpStrobeT  strobe,
  input  logic       cfgWrite,
  input  logic       turboEn,
  input  logic       setSel,
  input  logic [1:0] curCodeOne,
  input  logic [1:0] curCodeTwo,
  output logic       locked,
  output logic [2:0] pumpCur
);
  localparam int GOOD_W = $clog2(LOCK_CNT + 1);
  localparam int BAD_W  = $clog2(UNLOCK_CNT + 1);

  logic [GOOD_W-1:0] goodCnt;
  logic [BAD_W-1:0]  badCnt;
  logic              turboArmed;

  always_ff @(posedge clk) begin
    if (!rstN || cfgWrite) begin
      goodCnt    <= '0;
      badCnt     <= '0;
      locked     <= 1'b0;
      turboArmed <= 1'b1;
    end else if (strobe.cmpDone) begin
      if (!locked) begin
        badCnt <= '0;
        if (!strobe.cmpOk)
          goodCnt <= '0;
        else if (goodCnt == GOOD_W'(LOCK_CNT - 1)) begin
          goodCnt    <= '0;
          locked     <= 1'b1;
          turboArmed <= 1'b0;
        end else
          goodCnt <= goodCnt + 1'b1;
      end else begin
        goodCnt <= '0;
        if (strobe.cmpOk)
          badCnt <= '0;
        else if (badCnt == BAD_W'(UNLOCK_CNT - 1)) begin
          badCnt <= '0;
          locked <= 1'b0;
        end else
          badCnt <= badCnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (turboEn && turboArmed) pumpCur = CUR_TURBO;
    else                       pumpCur = {1'b0, (setSel ? curCodeOne : curCodeTwo)};
  end

  a_r6_lock_from_good: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(strobe.cmpDone && strobe.cmpOk));

  a_r7_unlock_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(cfgWrite || (strobe.cmpDone && !strobe.cmpOk)));

  a_r9_no_turbo_locked: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !pumpCur[2]);

  a_r10_rearm_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(turboArmed) |-> $past(cfgWrite));
endmodule

// File: rtl/pfd_turbo_ctrl.sv
module pfd_turbo_ctrl
  import pfd_pkg::*;
#(
  parameter int RST_DLY    = 2,
  parameter int WIDTH_W    = 8,
  parameter int LOCK_CNT   = 16,
  parameter int UNLOCK_CNT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refPulse,
  input  logic               fbPulse,
  input  logic               polarity,
  input  logic               turboEn,
  input  logic [1:0]         curCodeOne,
  input  logic [1:0]         curCodeTwo,
  input  logic               setSel,
  input  logic               cfgWrite,
  input  logic [WIDTH_W-1:0] lockThresh,
  output logic               pumpUp,
  output logic               pumpDn,
  output logic               locked,
  output logic [2:0]         pumpCur
);
  cmpStrobeT strobe;

  pfd_phase_core #(.RST_DLY(RST_DLY), .WIDTH_W(WIDTH_W)) uCore (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .fbPulse(fbPulse),
    .polarity(polarity), .lockThresh(lockThresh),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .strobe(strobe)
  );

  pfd_lock_ctrl #(.LOCK_CNT(LOCK_CNT), .UNLOCK_CNT(UNLOCK_CNT)) uCtrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrite(cfgWrite),
    .turboEn(turboEn), .setSel(setSel), .curCodeOne(curCodeOne),
    .curCodeTwo(curCodeTwo), .locked(locked), .pumpCur(pumpCur)
  );
endmodule

// File: tb/sim_pfd_turbo_ctrl.sv
module sim_pfd_turbo_ctrl;
  localparam int RST_DLY = 2, LOCK_CNT = 16, UNLOCK_CNT = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic refPulse = 1'b0, fbPulse = 1'b0, polarity = 1'b1, turboEn = 1'b1;
  logic [1:0] curCodeOne = 2'b11, curCodeTwo = 2'b11;
  logic setSel = 1'b1, cfgWrite = 1'b0;
  logic [7:0] lockThresh = 8'd4;
  logic pumpUp, pumpDn, locked;
  logic [2:0] pumpCur;

  pfd_turbo_ctrl u0 (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .fbPulse(fbPulse),
    .polarity(polarity), .turboEn(turboEn), .curCodeOne(curCodeOne),
    .curCodeTwo(curCodeTwo), .setSel(setSel), .cfgWrite(cfgWrite),
    .lockThresh(lockThresh), .pumpUp(pumpUp), .pumpDn(pumpDn),
    .locked(locked), .pumpCur(pumpCur)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0;
  bit mLocked = 0, mArmed = 1;
  int mGood = 0, mBad = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expCur();
    if (turboEn && mArmed) return 4;
    return setSel ? int'(curCodeOne) : int'(curCodeTwo);
  endfunction

  // One comparison: edges d cycles apart, then idle until settled.
  task automatic compare(bit refFirst, int d);
    int upOnly = 0, dnOnly = 0, both = 0;
    int ta = refFirst ? 0 : d;
    int tb = refFirst ? d : 0;
    bit good, wasLocked;
    for (int c = 0; c < d + RST_DLY + 6; c++) begin
      @(negedge clk);
      if (pumpUp && !pumpDn) upOnly++;
      if (pumpDn && !pumpUp) dnOnly++;
      if (pumpUp && pumpDn)  both++;
      refPulse = (c == ta);
      fbPulse  = (c == tb);
    end
    chk("R4/R3 up width", upOnly, (refFirst == polarity) ? d : 0);
    chk("R4/R3 dn width", dnOnly, (refFirst != polarity) ? d : 0);
    chk("R2 overlap", both, RST_DLY);
    good = d < int'(lockThresh);  // R5
    wasLocked = mLocked;
    if (!mLocked) begin
      mBad = 0;
      if (!good) mGood = 0;
      else if (++mGood == LOCK_CNT) begin mLocked = 1; mGood = 0; mArmed = 0; end
    end else begin
      mGood = 0;
      if (good) mBad = 0;
      else if (++mBad == UNLOCK_CNT) begin mLocked = 0; mBad = 0; end
    end
    chk(wasLocked ? "R7 locked" : "R6 locked", int'(locked), int'(mLocked));
    chk("R9 pumpCur", int'(pumpCur), expCur());
  endtask

  task automatic writeCfg();
    @(negedge clk); cfgWrite = 1'b1;
    @(negedge clk); cfgWrite = 1'b0;
    mLocked = 0; mGood = 0; mBad = 0; mArmed = 1;
    chk("R10 locked cleared", int'(locked), 0);
    chk("R10 turbo rearmed", int'(pumpCur), 4);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pumpUp", int'(pumpUp), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pumpUp", int'(pumpUp), 0);
    chk("R1 pumpDn", int'(pumpDn), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 pumpCur", int'(pumpCur), 4);

    // R3/R4/R5: sweep polarity, edge order and spacing.
    for (int p = 0; p < 2; p++)
      for (int f = 0; f < 2; f++)
        for (int d = 0; d < 7; d++) begin
          polarity = p[0];
          compare(f[0], d);
        end

    // R6: bad comparison restarts the good run, then a full run locks.
    curCodeOne = 2'b01; curCodeTwo = 2'b10; setSel = 1'b1; polarity = 1'b1;
    for (int i = 0; i < 10; i++) compare(1'b1, 1);
    compare(1'b0, 5);
    for (int i = 0; i < LOCK_CNT; i++) compare(1'b1, 2);
    chk("R6 locked after run", int'(locked), 1);
    chk("R8 code after lock", int'(pumpCur), 1);

    // R7: three bad, one good, then four bad.
    for (int i = 0; i < 3; i++) compare(1'b1, 6);
    compare(1'b0, 0);
    for (int i = 0; i < 3; i++) compare(1'b0, 4);
    chk("R7 still locked", int'(locked), 1);
    compare(1'b1, 4);
    chk("R7 unlocked", int'(locked), 0);
    chk("R9 no rearm on loss", int'(pumpCur), 1);

    // R8: all codes on both sets.
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          curCodeOne = a[1:0]; curCodeTwo = b[1:0]; setSel = s[0];
          #1 chk("R8 code select", int'(pumpCur), s[0] ? a : b);
        end

    // R10: relock, then a configuration write rearms turbo.
    for (int i = 0; i < LOCK_CNT; i++) compare(1'b0, 3);
    chk("R6 relocked", int'(locked), 1);
    writeCfg();

    // R9: turbo disabled shows the code while armed.
    @(negedge clk); turboEn = 1'b0; curCodeTwo = 2'b10; setSel = 1'b0;
    #1 chk("R9 turbo disabled", int'(pumpCur), 2);
    @(negedge clk); turboEn = 1'b1;
    #1 chk("R9 turbo enabled", int'(pumpCur), 4);

    // R5: threshold edge with a different limit.
    lockThresh = 8'd2;
    for (int i = 0; i < LOCK_CNT - 1; i++) compare(1'b1, 1);
    compare(1'b1, 2);
    chk("R5 width equal to limit is bad", int'(locked), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule